// File: doc/BRIEF.md
# Word-copy DMA into banked sample memory

This block copies a requested number of 16-bit words from a 16 KB source buffer into one 4 KB bank of a byte-addressed wave memory. A single start pulse carries the word count and the current values of two software-visible address registers (source and destination), plus the bank number. The engine works out its starting addresses from those registers, then runs a read handshake on the source port followed by a write handshake on the destination port for every word. Both addresses step by two bytes after each word and wrap inside their own windows.

At the start pulse the engine also computes the new values of the two address registers. The source register advances by twice the word count and the destination register by half the word count. These values appear on dedicated outputs so that the owner of the registers can write them back. A done pulse marks the end of the transfer. Arbitration against the playback engine for the wave memory is handled outside this block.

Top module: `wdma_top`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid_o`, `wr_valid_o` and `done_o` are low, and `src_upd_o` and `dst_upd_o` are zero.
- R2: The first source read address is `src_reg_i & 0x3FFE`. This is a 14-bit byte address with bit 0 forced to zero.
- R3: The first write address is `{bank_i, (dst_reg_i << 2) & 0xFFE}`. Bits 15:12 hold the bank latched at start, and bits 11:0 hold the byte offset inside the bank.
- R4: After each word, the source address becomes `(src + 2) & 0x3FFE` and the bank offset becomes `(off + 2) & 0xFFE`. Each wraps inside its own window, and the bank does not change.
- R5: A transfer of N words performs exactly N accepted reads and N accepted writes, alternating read then write, and the two valids are never high together. The write data equals the word returned for the preceding read. `wr_data_o[7:0]` is the byte for the even address and `wr_data_o[15:8]` is the byte for the following odd address.
- R6: Once raised, a valid stays high with its address (and, for writes, its data) stable until the matching ready is seen high at a clock edge.
- R7: `done_o` is high for exactly one cycle. That cycle follows the clock edge that accepts the last write.
- R8: From the cycle after start, `src_upd_o = src_reg_i + 2*N` and `dst_upd_o = dst_reg_i + (N >> 1)`, both modulo 2^16.
- R9: A start with N = 0 raises `done_o` in the cycle after the start edge, performs no reads or writes, and gives `src_upd_o` and `dst_upd_o` equal to the input registers.
- R10: A start pulse that arrives while a transfer is running is ignored. Addresses, word count and updated register values all stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| count_i | input | 16 | Number of words to copy |
| src_reg_i | input | 16 | Source address register value |
| dst_reg_i | input | 16 | Destination address register value |
| bank_i | input | 4 | Destination bank number |
| rd_valid_o | output | 1 | Source read request |
| rd_ready_i | input | 1 | Source read accepted, data valid |
| rd_addr_o | output | 14 | Source byte address (even) |
| rd_data_i | input | 16 | Source word |
| wr_valid_o | output | 1 | Bank write request |
| wr_ready_i | input | 1 | Bank write accepted |
| wr_addr_o | output | 16 | Wave memory byte address (even), bank in top bits |
| wr_data_o | output | 16 | Word to write, low byte at the even address |
| src_upd_o | output | 16 | Updated source register value |
| dst_upd_o | output | 16 | Updated destination register value |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit register and count width, a 14-bit source window, and 4-bit bank numbers over 12-bit bank offsets. With these sizes, word counts of up to a few dozen already carry both addresses across the top of their windows from starting points near the end. Directed runs place the source at 0x3FFC and the bank offset at 0xFFC, use counts of zero and one, use odd and high-bit register values, and pulse start in the middle of a transfer. Random ready stalls on both ports exercise the hold rules.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } wdma_state_e;
endpackage

// File: rtl/wdma_addr_gen.sv
module wdma_addr_gen #(
  parameter int REG_W  = 16,
  parameter int SRC_AW = 14,
  parameter int OFF_AW = 12,
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     step,
  input  logic [REG_W-1:0]         src_reg,
  input  logic [REG_W-1:0]         dst_reg,
  input  logic [BANK_W-1:0]        bank,
  output logic [SRC_AW-1:0]        src_addr,
  output logic [BANK_W+OFF_AW-1:0] dst_addr
);
  localparam logic [SRC_AW-1:0] SRC_STEP = SRC_AW'(2);
  localparam logic [OFF_AW-1:0] OFF_STEP = OFF_AW'(2);

  logic [SRC_AW-1:0] src_q;
  logic [OFF_AW-1:0] off_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      off_q  <= '0;
      bank_q <= '0;
    end else if (load) begin
      // word aligned inside the source window
      src_q  <= {src_reg[SRC_AW-1:1], 1'b0};
      // register scaled by four, kept inside the bank window
      off_q  <= {dst_reg[OFF_AW-3:0], 2'b00};
      bank_q <= bank;
    end else if (step) begin
      src_q <= src_q + SRC_STEP;
      off_q <= off_q + OFF_STEP;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = {bank_q, off_q};

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (src_q == $past(src_q) + SRC_STEP)) // R4
    else $error("source address did not advance by one word");
  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(bank_q)) // R4
    else $error("bank changed during a transfer");
  AST_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (src_q[0] == 1'b0) && (off_q[0] == 1'b0)) // R2
    else $error("unaligned address");
endmodule

// File: rtl/wdma_reg_upd.sv
module wdma_reg_upd #(
  parameter int REG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic [REG_W-1:0] src_reg,
  input  logic [REG_W-1:0] dst_reg,
  output logic [REG_W-1:0] src_upd,
  output logic [REG_W-1:0] dst_upd
);
  logic [CNT_W:0]   cnt_x2;
  logic [REG_W-1:0] src_inc;
  logic [REG_W-1:0] dst_inc;

  always_comb begin
    cnt_x2  = {count, 1'b0};
    src_inc = REG_W'(cnt_x2);
    dst_inc = REG_W'(count >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_upd <= '0;
      dst_upd <= '0;
    end else if (load) begin
      src_upd <= src_reg + src_inc;
      dst_upd <= dst_reg + dst_inc;
    end
  end

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> ($stable(src_upd) && $stable(dst_upd))) // R10
    else $error("register update changed without a start");
endmodule

// File: rtl/wdma_seq.sv
module wdma_seq
  import wdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_ready,
  input  logic             wr_ready,
  output logic             rd_valid,
  output logic             wr_valid,
  output logic             done,
  output logic             load,
  output logic             step,
  output logic             cap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  wdma_state_e state_q;
  logic [CNT_W-1:0] rem_q;

  assign rd_valid = (state_q == ST_READ);
  assign wr_valid = (state_q == ST_WRITE);
  assign done     = (state_q == ST_DONE);
  assign load     = start && (state_q == ST_IDLE);
  assign cap      = rd_valid && rd_ready;
  assign step     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load) begin
          rem_q   <= count;
          state_q <= (count == '0) ? ST_DONE : ST_READ;
        end
        ST_READ: if (cap) state_q <= ST_WRITE;
        ST_WRITE: if (step) begin
          rem_q   <= rem_q - ONE;
          state_q <= (rem_q == ONE) ? ST_DONE : ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> rd_valid) // R6
    else $error("read request dropped before acceptance");
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> wr_valid) // R6
    else $error("write request dropped before acceptance");
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid)) // R5
    else $error("read and write requested together");
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) // R7
    else $error("done longer than one cycle");
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (rst)
    (load && count == '0) |=> (done && !rd_valid)) // R9
    else $error("zero count did not complete at once");
  AST_LAST_WR: assert property (@(posedge clk) disable iff (rst)
    (step && rem_q == ONE) |=> done) // R7
    else $error("no done after last write");
endmodule

// File: rtl/wdma_top.sv
module wdma_top #(
  parameter int REG_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SRC_AW = 14,
  parameter int OFF_AW = 12,
  parameter int BANK_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [REG_W-1:0]         src_reg_i,
  input  logic [REG_W-1:0]         dst_reg_i,
  input  logic [BANK_W-1:0]        bank_i,
  output logic                     rd_valid_o,
  input  logic                     rd_ready_i,
  output logic [SRC_AW-1:0]        rd_addr_o,
  input  logic [DATA_W-1:0]        rd_data_i,
  output logic                     wr_valid_o,
  input  logic                     wr_ready_i,
  output logic [BANK_W+OFF_AW-1:0] wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic [REG_W-1:0]         src_upd_o,
  output logic [REG_W-1:0]         dst_upd_o,
  output logic                     done_o
);
  logic load, step, cap;
  logic [DATA_W-1:0] word_q;

  wdma_seq #(.CNT_W(CNT_W)) i_seq (
    .clk(clk), .rst(rst), .start(start_i), .count(count_i),
    .rd_ready(rd_ready_i), .wr_ready(wr_ready_i),
    .rd_valid(rd_valid_o), .wr_valid(wr_valid_o), .done(done_o),
    .load(load), .step(step), .cap(cap)
  );

  wdma_addr_gen #(.REG_W(REG_W), .SRC_AW(SRC_AW), .OFF_AW(OFF_AW), .BANK_W(BANK_W)) i_addr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .src_reg(src_reg_i), .dst_reg(dst_reg_i), .bank(bank_i),
    .src_addr(rd_addr_o), .dst_addr(wr_addr_o)
  );

  wdma_reg_upd #(.REG_W(REG_W), .CNT_W(CNT_W)) i_upd (
    .clk(clk), .rst(rst), .load(load), .count(count_i),
    .src_reg(src_reg_i), .dst_reg(dst_reg_i),
    .src_upd(src_upd_o), .dst_upd(dst_upd_o)
  );

  always_ff @(posedge clk) begin
    if (rst)      word_q <= '0;
    else if (cap) word_q <= rd_data_i;
  end

  assign wr_data_o = word_q;

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> ($stable(wr_addr_o) && $stable(wr_data_o))) // R6
    else $error("write address or data moved while waiting");
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_addr_o)) // R6
    else $error("read address moved while waiting");
  AST_WR_DATA: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_ready_i) |=> (wr_data_o == $past(rd_data_i))) // R5
    else $error("write data differs from read word");
endmodule

// File: tb/test_wdma_top.sv
module test_wdma_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [15:0] src_reg_i = '0;
  logic [15:0] dst_reg_i = '0;
  logic [3:0]  bank_i = '0;
  logic        rd_valid_o, wr_valid_o, done_o;
  logic        rd_ready_i = 1'b0;
  logic        wr_ready_i = 1'b0;
  logic [13:0] rd_addr_o;
  logic [15:0] rd_data_i;
  logic [15:0] wr_addr_o, wr_data_o, src_upd_o, dst_upd_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [13:0] m_src;
  logic [11:0] m_off;
  logic [3:0]  m_bank;
  int          m_cnt;
  int          m_wr;
  int          m_rd;

  function automatic logic [15:0] src_word(logic [13:0] a);
    return {a[7:0] ^ 8'hA5, a[13:8], 2'b10};
  endfunction

  assign rd_data_i = src_word(rd_addr_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  wdma_top i_wdma_top (
    .clk(clk), .rst(rst), .start_i(start_i), .count_i(count_i),
    .src_reg_i(src_reg_i), .dst_reg_i(dst_reg_i), .bank_i(bank_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .src_upd_o(src_upd_o),
    .dst_upd_o(dst_upd_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; fails++;
        $display("FAIL watchdog actual=0x%0h expected=0x%0h", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  // port responder and access checker
  initial begin
    forever begin
      @(negedge clk);
      rd_ready_i = ($urandom % 4) != 0;
      wr_ready_i = ($urandom % 3) != 0;
      if (!rst) begin
        if (rd_valid_o && rd_ready_i) begin
          // R2 R4: source address sequence
          check(rd_addr_o == m_src, (m_rd == 0) ? "R2" : "R4", 32'(rd_addr_o), 32'(m_src));
          check(m_rd == m_wr, "R5 read order", m_rd, m_wr);
          m_rd++;
        end
        if (wr_valid_o && wr_ready_i) begin
          // R3 R4: destination address
          check(wr_addr_o == {m_bank, m_off}, (m_wr == 0) ? "R3" : "R4",
                32'(wr_addr_o), 32'({m_bank, m_off}));
          check(wr_data_o == src_word(m_src), "R5 data", 32'(wr_data_o), 32'(src_word(m_src)));
          check(m_wr < m_cnt, "R5 extra write", m_wr, m_cnt);
          m_src = m_src + 14'd2;
          m_off = m_off + 12'd2;
          m_wr++;
        end
      end
    end
  end

  task automatic run_xfer(input logic [15:0] src, input logic [15:0] dst,
                          input logic [3:0] bank, input int cnt, input bit inject);
    int wait_n;
    m_src  = src[13:0] & 14'h3FFE;
    m_off  = 12'(dst << 2) & 12'hFFE;
    m_bank = bank;
    m_cnt  = cnt;
    m_wr   = 0;
    m_rd   = 0;
    @(negedge clk);
    src_reg_i = src; dst_reg_i = dst; bank_i = bank; count_i = 16'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    if (inject) begin
      // R10: start while busy, other values
      src_reg_i = ~src; dst_reg_i = dst ^ 16'h1234; bank_i = ~bank; count_i = 16'(cnt + 7);
    end else begin
      start_i = 1'b0;
    end
    if (cnt == 0) begin
      check(done_o == 1'b1, "R9 done", 32'(done_o), 1);
    end else begin
      wait_n = 0;
      while (!done_o && wait_n < 20000) begin
        @(negedge clk);
        start_i = 1'b0;
        wait_n++;
      end
    end
    start_i = 1'b0;
    check(m_wr == cnt, "R5 write count", m_wr, cnt);
    check(m_rd == cnt, "R5 read count", m_rd, cnt);
    check(src_upd_o == 16'(src + 16'(cnt * 2)), inject ? "R10 src" : "R8 src",
          32'(src_upd_o), 32'(16'(src + 16'(cnt * 2))));
    check(dst_upd_o == 16'(dst + 16'(cnt / 2)), inject ? "R10 dst" : "R8 dst",
          32'(dst_upd_o), 32'(16'(dst + 16'(cnt / 2))));
    @(negedge clk);
    check(done_o == 1'b0, "R7 single pulse", 32'(done_o), 0);
    check(!rd_valid_o && !wr_valid_o, "R7 idle after done", 32'({rd_valid_o, wr_valid_o}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_src = '0; m_off = '0; m_bank = '0; m_cnt = 0; m_wr = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!rd_valid_o && !wr_valid_o && !done_o, "R1 valids",
          32'({rd_valid_o, wr_valid_o, done_o}), 0);
    check(src_upd_o == 16'h0 && dst_upd_o == 16'h0, "R1 regs",
          32'({src_upd_o, dst_upd_o}), 0);

    // directed corners
    run_xfer(16'h3FFC, 16'h03FF, 4'hA, 5, 1'b0);   // R4 both windows wrap
    run_xfer(16'hFFFF, 16'hFFFF, 4'hF, 3, 1'b0);   // R2 R3 high and odd bits masked
    run_xfer(16'h1235, 16'h0042, 4'h3, 0, 1'b0);   // R9 zero count
    run_xfer(16'h0000, 16'h0000, 4'h0, 1, 1'b0);   // single word
    run_xfer(16'h0100, 16'h0010, 4'h5, 9, 1'b1);   // R10 start while busy
    run_xfer(16'hFFFF, 16'hFFFF, 4'h1, 2, 1'b0);   // R8 register wrap

    for (int k = 0; k < 40; k++) begin
      run_xfer(16'($urandom), 16'($urandom), 4'($urandom), int'($urandom % 41),
               ($urandom % 5) == 0);
    end
    finish_run();
  end
endmodule